// File: doc/BRIEF.md
# Banked Window Bridge for an 8-bit CPU

This block sits between a small 8-bit processor with a 16-bit address map and a much larger 24-bit bus. The top half of the small processor's map (0x8000-0xFFFF) is a 32 KB window into the large space. A 9-bit bank number chooses which 32 KB slice of the large space the window shows. The bank number is loaded one bit per write: each write shifts the register right by one place and puts the written bit in at the top. Far-side reads and writes are single bytes. While a far access is outstanding, the small processor is held waiting until the far bus acknowledges it.

The lower half of the map is decoded locally into three targets, each with its own chip select:
- an 8 KB local RAM, for addresses below 0x4000 (the RAM is mirrored);
- a sound synthesizer port, for 0x4000-0x5FFF, reads and writes;
- a write-only tone generator port, on four odd addresses near 0x7F11.

A 16-bit access from the small processor is carried out as two byte accesses in sequence.

The processor side uses a start pulse and a done pulse. The bridge ignores any start pulse that arrives while it is busy. Each local byte access takes one cycle. Each far byte access lasts until the acknowledge arrives.

Top module: `bank_window_bridge`

## Requirements
- R1: After reset the bank register is 0, `s_busy` and `s_done` are low, and no chip select or far request is active, so the first window access reaches far address 0x000000 + (addr & 0x7FFF).
- R2: A write whose address has upper byte 0x60 updates the bank register: the register shifts right by one, data bit 0 enters bit 8, and data bits 7..1 are ignored. Reads of 0x60xx leave the bank unchanged.
- R3: An access to 0x8000-0xFFFF raises `f_req` with `f_addr` = bank*32768 + (addr & 0x7FFF). `dev_we` and `dev_wdata` carry the direction and the data byte.
- R4: During a far access, `f_req`, `f_addr` and `dev_we` are held steady and `s_busy` stays high until `f_ack`. The read byte is taken from `f_rdata` in the acknowledge cycle. A start pulse that arrives while the bridge is busy is ignored.
- R5: Reads and writes to 0x4000-0x5FFF assert `fm_cs` for one cycle, and a read returns `fm_rdata`.
- R6: A write to an address where (addr & 0xFFF9) == 0x7F11 asserts `psg_cs` for one cycle. A read of those addresses asserts no chip select.
- R7: Addresses below 0x4000 assert `ram_cs` with `ram_addr` = addr & 0x1FFF (the RAM is mirrored), and a read returns `ram_rdata`.
- R8: A wide access performs the low byte at addr, using `s_wdata[7:0]`, and then the high byte at addr+1, using `s_wdata[15:8]`. A wide read returns {byte at addr+1, byte at addr}. A byte read returns its byte in `s_rdata[7:0]` with the upper byte 0.
- R9: Reads of unmapped addresses (0x6000-0x7FFF, except as a bank or tone target on a write) return 0x00. Writes to unmapped addresses change nothing. At most one of `ram_cs`, `fm_cs`, `psg_cs` and `f_req` is active in any cycle.
- R10: `s_done` is a one-cycle pulse. It rises two cycles after the start pulse for a local byte access, three cycles after it for a wide local access, and N cycles later still when the far acknowledge comes N cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_start | input | 1 | One-cycle pulse that starts an access |
| s_we | input | 1 | 1 = write, 0 = read |
| s_wide | input | 1 | 1 = 16-bit access, split into two bytes |
| s_addr | input | 16 | Small-CPU address |
| s_wdata | input | 16 | Write data; the low byte is used first |
| s_busy | output | 1 | Access in progress (wait state) |
| s_done | output | 1 | One-cycle completion pulse |
| s_rdata | output | 16 | Read result, valid with s_done |
| dev_addr | output | 16 | Address of the current byte |
| dev_we | output | 1 | Direction of the current byte |
| dev_wdata | output | 8 | Data of the current byte |
| ram_cs | output | 1 | Local RAM select |
| ram_addr | output | 13 | Local RAM address |
| ram_rdata | input | 8 | Local RAM read data |
| fm_cs | output | 1 | Synthesizer port select |
| fm_rdata | input | 8 | Synthesizer read data |
| psg_cs | output | 1 | Tone generator write select |
| f_req | output | 1 | Far bus request |
| f_addr | output | 24 | Far bus byte address |
| f_rdata | input | 8 | Far bus read data, valid with f_ack |
| f_ack | input | 1 | Far bus acknowledge |

## Verification
The embedded properties check, on every cycle:
- that the targets are mutually exclusive;
- that the far request, its address and its direction hold steady through a wait;
- that tone-port selects occur only on writes and RAM selects only in the low region;
- that the bank register moves only on a bank write, with the written bit landing at the top;
- that the done pulse is a single cycle.

Only the directed scenarios can show the rest:
- the bank value built up over a sequence of serial writes, and the far address it produces;
- the byte ordering of wide accesses;
- the RAM mirroring;
- reads of unmapped space returning zero;
- exact completion latencies;
- a start pulse being dropped while the bridge is busy.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  parameter int SA_W   = 16;
  parameter int BYTE_W = 8;
  parameter int BANK_W = 9;
  parameter int WIN_W  = 15;
  parameter int RAM_AW = 13;
  localparam int FA_W  = BANK_W + WIN_W;
  localparam int WD_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    RG_NONE, RG_RAM, RG_FM, RG_PSG, RG_BANK, RG_FAR
  } region_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_ACT, SQ_DONE
  } seq_state_e;

  function automatic region_e decode_region(input logic [SA_W-1:0] a, input logic we);
    region_e r;
    if (a[SA_W-1])                                r = RG_FAR;
    else if (a[15:13] == 3'b010)                  r = RG_FM;
    else if (we && ((a & 16'hFFF9) == 16'h7F11))  r = RG_PSG;
    else if (we && (a[15:8] == 8'h60))            r = RG_BANK;
    else if (a[15:14] == 2'b00)                   r = RG_RAM;
    else                                          r = RG_NONE;
    return r;
  endfunction

  function automatic logic [FA_W-1:0] far_address(input logic [BANK_W-1:0] bank,
                                                  input logic [SA_W-1:0] a);
    return {bank, a[WIN_W-1:0]};
  endfunction

  function automatic logic [BANK_W-1:0] bank_shift(input logic [BANK_W-1:0] bank,
                                                   input logic bit_in);
    return {bit_in, bank[BANK_W-1:1]};
  endfunction
endpackage

// File: rtl/bwb_bank_reg.sv
module bwb_bank_reg
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        bank_q <= '0;
    else if (shift_en) bank_q <= bank_shift(bank_q, bit_in);
  end

  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bank_q));
  assert_bank_topbit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> bank_q[BANK_W-1] == $past(bit_in));
endmodule

// File: rtl/bwb_decode.sv
module bwb_decode
  import bwb_pkg::*;
(
  input  logic [SA_W-1:0] addr,
  input  logic            we,
  output region_e         region
);
  always_comb region = decode_region(addr, we);
endmodule

// File: rtl/bwb_seq.sv
module bwb_seq
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_start,
  input  logic              s_we,
  input  logic              s_wide,
  input  logic [SA_W-1:0]   s_addr,
  input  logic [WD_W-1:0]   s_wdata,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_rdata,
  output logic [SA_W-1:0]   cur_addr,
  output logic [BYTE_W-1:0] cur_wdata,
  output logic              cur_we,
  output logic              active,
  output logic              byte_fire,
  output logic              s_busy,
  output logic              s_done,
  output logic [WD_W-1:0]   s_rdata
);
  seq_state_e            state;
  logic [SA_W-1:0]       cmd_addr;
  logic [WD_W-1:0]       cmd_wdata;
  logic                  cmd_wide;
  logic                  idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      cmd_we    <= 1'b0;
      cmd_wide  <= 1'b0;
      idx       <= 1'b0;
      s_rdata   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (s_start) begin
          cmd_addr  <= s_addr;
          cmd_wdata <= s_wdata;
          cmd_we    <= s_we;
          cmd_wide  <= s_wide;
          idx       <= 1'b0;
          s_rdata   <= '0;
          state     <= SQ_ACT;
        end
        SQ_ACT: if (byte_done) begin
          if (!cmd_we) begin
            if (idx) s_rdata[WD_W-1:BYTE_W] <= byte_rdata;
            else     s_rdata[BYTE_W-1:0]    <= byte_rdata;
          end
          if (cmd_wide && !idx) idx   <= 1'b1;
          else                  state <= SQ_DONE;
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  logic cmd_we;
  assign cur_addr  = cmd_addr + SA_W'(idx);
  assign cur_wdata = idx ? cmd_wdata[WD_W-1:BYTE_W] : cmd_wdata[BYTE_W-1:0];
  assign cur_we    = cmd_we;
  assign active    = (state == SQ_ACT);
  assign byte_fire = active && byte_done;
  assign s_busy    = (state != SQ_IDLE);
  assign s_done    = (state == SQ_DONE);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |=> !s_done && !s_busy);
  assert_wait_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !byte_done) |=> active && $stable(cur_addr));
endmodule

// File: rtl/bank_window_bridge.sv
module bank_window_bridge
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_start,
  input  logic              s_we,
  input  logic              s_wide,
  input  logic [SA_W-1:0]   s_addr,
  input  logic [WD_W-1:0]   s_wdata,
  output logic              s_busy,
  output logic              s_done,
  output logic [WD_W-1:0]   s_rdata,
  output logic [SA_W-1:0]   dev_addr,
  output logic              dev_we,
  output logic [BYTE_W-1:0] dev_wdata,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              fm_cs,
  input  logic [BYTE_W-1:0] fm_rdata,
  output logic              psg_cs,
  output logic              f_req,
  output logic [FA_W-1:0]   f_addr,
  input  logic [BYTE_W-1:0] f_rdata,
  input  logic              f_ack
);
  region_e               region;
  logic                  active;
  logic                  byte_fire;
  logic                  byte_done;
  logic [BYTE_W-1:0]     byte_rdata;
  logic [BANK_W-1:0]     bank_q;
  logic                  bank_wr;

  bwb_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .s_start(s_start), .s_we(s_we), .s_wide(s_wide),
    .s_addr(s_addr), .s_wdata(s_wdata),
    .byte_done(byte_done), .byte_rdata(byte_rdata),
    .cur_addr(dev_addr), .cur_wdata(dev_wdata), .cur_we(dev_we),
    .active(active), .byte_fire(byte_fire),
    .s_busy(s_busy), .s_done(s_done), .s_rdata(s_rdata)
  );

  bwb_decode u_dec (
    .addr(dev_addr), .we(dev_we), .region(region)
  );

  assign bank_wr = byte_fire && (region == RG_BANK);

  bwb_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n),
    .shift_en(bank_wr), .bit_in(dev_wdata[0]), .bank_q(bank_q)
  );

  assign ram_cs    = active && (region == RG_RAM);
  assign fm_cs     = active && (region == RG_FM);
  assign psg_cs    = active && (region == RG_PSG);
  assign f_req     = active && (region == RG_FAR);
  assign ram_addr  = dev_addr[RAM_AW-1:0];
  assign f_addr    = far_address(bank_q, dev_addr);
  assign byte_done = (region != RG_FAR) || f_ack;

  always_comb begin
    case (region)
      RG_RAM:  byte_rdata = ram_rdata;
      RG_FM:   byte_rdata = fm_rdata;
      RG_FAR:  byte_rdata = f_rdata;
      default: byte_rdata = '0;
    endcase
  end

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, fm_cs, psg_cs, f_req}));
  assert_far_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && !f_ack) |=> f_req && $stable(f_addr) && $stable(dev_we));
  assert_psg_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    psg_cs |-> dev_we);
  assert_ram_low_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (dev_addr[15:14] == 2'b00));
  assert_far_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f_req |-> s_busy && !s_done);
endmodule

// File: tb/bank_window_bridge_tb.sv
module bank_window_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_start = 1'b0, s_we = 1'b0, s_wide = 1'b0;
  logic [15:0] s_addr = '0, s_wdata = '0;
  logic        s_busy, s_done;
  logic [15:0] s_rdata, dev_addr;
  logic        dev_we;
  logic [7:0]  dev_wdata;
  logic        ram_cs, fm_cs, psg_cs, f_req;
  logic [12:0] ram_addr;
  logic [7:0]  ram_rdata;
  logic [7:0]  fm_rdata = 8'h00;
  logic [23:0] f_addr;
  logic [7:0]  f_rdata = 8'h00;
  logic        f_ack = 1'b0;

  int errors = 0, checks = 0;
  int far_lat = 0, lat_cnt = 0;
  int ram_wr_cnt = 0, fm_cnt = 0, psg_cnt = 0, far_cnt = 0, unstable = 0;
  logic [7:0]  psg_last = '0;
  logic [23:0] far_last = '0, prev_faddr = '0;
  logic        far_last_we = 1'b0;
  logic [7:0]  far_last_wd = '0;
  logic [7:0]  mem [0:8191];
  int bank_m = 0;

  always #2.5 clk = ~clk;

  bank_window_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .s_start(s_start), .s_we(s_we), .s_wide(s_wide),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_busy(s_busy), .s_done(s_done),
    .s_rdata(s_rdata), .dev_addr(dev_addr), .dev_we(dev_we), .dev_wdata(dev_wdata),
    .ram_cs(ram_cs), .ram_addr(ram_addr), .ram_rdata(ram_rdata), .fm_cs(fm_cs),
    .fm_rdata(fm_rdata), .psg_cs(psg_cs), .f_req(f_req), .f_addr(f_addr),
    .f_rdata(f_rdata), .f_ack(f_ack)
  );

  assign ram_rdata = mem[ram_addr];

  function automatic logic [7:0] far_model(input logic [23:0] a);
    return a[7:0] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [23:0] exp_far(input int bank, input logic [15:0] a);
    return 24'(bank * 32768 + int'(a & 16'h7FFF));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Device models on the far and local sides, all acting at the falling edge
  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    forever begin
      @(negedge clk);
      if (ram_cs && dev_we) begin mem[ram_addr] = dev_wdata; ram_wr_cnt++; end
      if (fm_cs) fm_cnt++;
      if (psg_cs) begin psg_cnt++; psg_last = dev_wdata; end
      if (f_req && !f_ack && lat_cnt > 0 && f_addr !== prev_faddr) unstable++;
      prev_faddr = f_addr;
      if (f_ack) begin
        f_ack = 1'b0; lat_cnt = 0;
      end else if (f_req) begin
        if (lat_cnt >= far_lat) begin
          f_ack = 1'b1; f_rdata = far_model(f_addr);
          far_cnt++; far_last = f_addr; far_last_we = dev_we; far_last_wd = dev_wdata;
        end else lat_cnt++;
      end
    end
  end

  task automatic access(input logic we, input logic wide, input logic [15:0] a,
                        input logic [15:0] wd, output logic [15:0] rd, output int cyc);
    @(negedge clk);
    s_start = 1'b1; s_we = we; s_wide = wide; s_addr = a; s_wdata = wd;
    cyc = 0;
    rd = '0;
    do begin
      @(negedge clk);
      s_start = 1'b0;
      cyc++;
    end while (!s_done && cyc < 100);
    rd = s_rdata;
    @(negedge clk);
    chk("R10 done one cycle", {31'b0, s_done}, 0);
  endtask

  task automatic bank_write(input logic b, input logic [15:0] a);
    logic [15:0] rd; int cyc;
    access(1'b1, 1'b0, a, {8'h00, 7'h7F, b}, rd, cyc);
    bank_m = (bank_m >> 1) | (int'(b) << 8);
  endtask

  task automatic t_reset;
    logic [15:0] rd; int cyc;
    chk("R1 busy", {31'b0, s_busy}, 0);
    chk("R1 done", {31'b0, s_done}, 0);
    chk("R1 selects", {28'b0, ram_cs, fm_cs, psg_cs, f_req}, 0);
    access(1'b0, 1'b0, 16'h8123, 16'h0, rd, cyc);
    chk("R1 far address bank 0", far_last, 24'h000123);
    chk("R3 far read data", rd, {8'h00, far_model(24'h000123)});
    chk("R10 far latency 0", cyc, 2);
  endtask

  task automatic t_bank;
    logic [15:0] rd; int cyc;
    int target = 'h1A5;
    for (int i = 0; i < 9; i++) bank_write(1'(target >> i), 16'h6000 + 16'(i * 3));
    chk("R2 model bank", bank_m, target);
    access(1'b0, 1'b0, 16'hFFFF, 16'h0, rd, cyc);
    chk("R2 R3 far address after serial load", far_last, exp_far(bank_m, 16'hFFFF));
    chk("R3 far read data", rd, {8'h00, far_model(exp_far(bank_m, 16'hFFFF))});
    bank_write(1'b1, 16'h60FE);
    access(1'b0, 1'b0, 16'h8000, 16'h0, rd, cyc);
    chk("R2 extra shift", far_last, exp_far(bank_m, 16'h8000));
    access(1'b1, 1'b0, 16'h6100, 16'h0001, rd, cyc);
    access(1'b0, 1'b0, 16'h6042, 16'h0, rd, cyc);
    chk("R9 read of bank address returns 0", rd, 0);
    access(1'b1, 1'b0, 16'h9234, 16'h0077, rd, cyc);
    chk("R2 R9 bank unchanged by 0x61xx write and read", far_last, exp_far(bank_m, 16'h9234));
    chk("R3 far write dir", {31'b0, far_last_we}, 1);
    chk("R3 far write data", far_last_wd, 8'h77);
  endtask

  task automatic t_far_wait;
    logic [15:0] rd; int cyc; int rcnt; int fcnt;
    far_lat = 4;
    rcnt = ram_wr_cnt; fcnt = far_cnt;
    @(negedge clk);
    s_start = 1'b1; s_we = 1'b0; s_wide = 1'b0; s_addr = 16'h8010;
    @(negedge clk); s_start = 1'b0;
    @(negedge clk);
    chk("R4 busy during wait", {31'b0, s_busy}, 1);
    chk("R4 request held", {31'b0, f_req}, 1);
    s_start = 1'b1; s_we = 1'b1; s_addr = 16'h0200; s_wdata = 16'h0011;
    @(negedge clk); s_start = 1'b0;
    cyc = 0;
    while (!s_done && cyc < 100) begin @(negedge clk); cyc++; end
    rd = s_rdata;
    chk("R4 read data at ack", rd, {8'h00, far_model(exp_far(bank_m, 16'h8010))});
    repeat (3) @(negedge clk);
    chk("R4 start while busy ignored", ram_wr_cnt, rcnt);
    chk("R4 single far access", far_cnt, fcnt + 1);
    chk("R4 address stable during wait", unstable, 0);
    access(1'b0, 1'b0, 16'h8010, 16'h0, rd, cyc);
    chk("R10 far latency 4", cyc, 6);
    access(1'b0, 1'b0, 16'h0200, 16'h0, rd, cyc);
    chk("R4 ignored write left RAM untouched", rd, 0);
    far_lat = 0;
  endtask

  task automatic t_fm;
    logic [15:0] rd; int cyc; int c0;
    fm_rdata = 8'h3C; c0 = fm_cnt;
    access(1'b0, 1'b0, 16'h4000, 16'h0, rd, cyc);
    chk("R5 fm read data", rd, 16'h003C);
    chk("R5 fm select on read", fm_cnt, c0 + 1);
    access(1'b1, 1'b0, 16'h5FFF, 16'h00AA, rd, cyc);
    chk("R5 fm select on write", fm_cnt, c0 + 2);
    access(1'b0, 1'b0, 16'h6000, 16'h0, rd, cyc);
    chk("R9 unmapped read returns 0", rd, 0);
    chk("R9 no fm select above 0x5FFF", fm_cnt, c0 + 2);
  endtask

  task automatic t_psg;
    logic [15:0] rd; int cyc; int c0;
    c0 = psg_cnt;
    access(1'b1, 1'b0, 16'h7F15, 16'h009B, rd, cyc);
    chk("R6 psg select", psg_cnt, c0 + 1);
    chk("R6 psg data", psg_last, 8'h9B);
    access(1'b1, 1'b0, 16'h7F17, 16'h0044, rd, cyc);
    chk("R6 psg 0x7F17", psg_last, 8'h44);
    access(1'b1, 1'b0, 16'h7F19, 16'h0055, rd, cyc);
    chk("R6 0x7F19 not psg", psg_cnt, c0 + 2);
    access(1'b0, 1'b0, 16'h7F11, 16'h0, rd, cyc);
    chk("R6 R9 psg read returns 0", rd, 0);
    chk("R6 psg read no select", psg_cnt, c0 + 2);
  endtask

  task automatic t_ram;
    logic [15:0] rd; int cyc;
    access(1'b1, 1'b0, 16'h2ABC, 16'h005E, rd, cyc);
    chk("R7 ram write masked address", mem[13'h0ABC], 8'h5E);
    chk("R10 local latency", cyc, 2);
    access(1'b0, 1'b0, 16'h0ABC, 16'h0, rd, cyc);
    chk("R7 ram mirror read", rd, 16'h005E);
  endtask

  task automatic t_wide;
    logic [15:0] rd; int cyc;
    access(1'b1, 1'b1, 16'h0100, 16'hA1B2, rd, cyc);
    chk("R8 low byte first", mem[13'h0100], 8'hB2);
    chk("R8 high byte at addr+1", mem[13'h0101], 8'hA1);
    access(1'b0, 1'b1, 16'h0100, 16'h0, rd, cyc);
    chk("R8 wide read", rd, 16'hA1B2);
    chk("R10 wide local latency", cyc, 3);
    far_lat = 1;
    access(1'b0, 1'b1, 16'h8FFE, 16'h0, rd, cyc);
    chk("R8 wide far read", rd, {far_model(exp_far(bank_m, 16'h8FFF)),
                                 far_model(exp_far(bank_m, 16'h8FFE))});
    chk("R8 second far address", far_last, exp_far(bank_m, 16'h8FFF));
    far_lat = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank();
    t_far_wait();
    t_fm();
    t_psg();
    t_ram();
    t_wide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule